// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a single configuration requester and a set of downstream function ports. Each request carries a 32-bit address, an access length of 1, 2 or 4 bytes, a direction and write data. The router splits the address into a bus number, a device/function number and a register offset. The device/function number selects one of 256 slots, and a parameter mask says which slots are populated. A request to bus zero that lands on a populated slot goes, one cycle later, to exactly one downstream port. The port is chosen from the device number, and the function number travels with the request.

Requests that miss are completed inside the router. A miss is either a nonzero bus number or an empty slot. A missed write disappears without a trace. A missed read returns all ones, cut to the access length, with no downstream activity. Only one request is in flight at a time. While a forwarded read waits for its port, the router raises `busy` and ignores new requests.

Top module: `cfg_access_router`

## Requirements
- R1: Address bits 23:16 are the bus number, bits 15:8 the device/function number (device = bits 15:11, function = bits 10:8), and bits 7:0 the register offset. A hit goes to port (device mod NUM_PORTS), with `fwd_func` equal to the function number. Bits 31:24 take no part in routing.
- R2: One cycle after an accepted hit, exactly one bit of `fwd_valid` is high, for one cycle. `fwd_write`, `fwd_offset`, `fwd_len` and `fwd_wdata` then equal the request's direction, offset, length and data, unchanged.
- R3: A write whose bus number is not zero, or whose slot is absent from the presence mask, raises no `fwd_valid` bit, no `rsp_valid` and no `busy`.
- R4: A read that misses gives `rsp_valid` one cycle after acceptance, with `rsp_rdata` = 0x000000FF for length 1, 0x0000FFFF for length 2 and 0xFFFFFFFF for length 4 (length is the 3-bit value 1, 2 or 4).
- R5: A missed read whose length is any other value (0, 3, 5, 6, 7) returns 0xFFFFFFFF, as for length 4.
- R6: After a read hit, `busy` is high from the cycle after acceptance until the response. `rsp_valid` rises one cycle after the selected port raises its `fwd_rsp_valid` bit, and carries that port's data. A response from any other port is ignored.
- R7: While `busy` is high, a request on `req_valid` is ignored: it raises no `fwd_valid` bit and no response.
- R8: After reset, `busy`, `rsp_valid` and every `fwd_valid` bit are low.
- R9: A write that hits never raises `busy` or `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Configuration address |
| req_len | input | 3 | Access length in bytes |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | A forwarded read awaits its response |
| rsp_valid | output | 1 | Read response, one-cycle pulse |
| rsp_rdata | output | 32 | Read response data |
| fwd_valid | output | NUM_PORTS | One-hot forward strobe per port |
| fwd_write | output | 1 | Forwarded direction |
| fwd_func | output | 3 | Forwarded function number |
| fwd_offset | output | 8 | Forwarded register offset |
| fwd_len | output | 3 | Forwarded length |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_rsp_valid | input | NUM_PORTS | Per-port read completion |
| fwd_rsp_rdata | input | 32*NUM_PORTS | Per-port read data, port p in bits 32p+31:32p |

## Verification
Forward strobes and missed-read responses are due one cycle after the accepting edge. A forwarded read's response is due one cycle after the edge that sees the port's completion. Missed writes must produce nothing at any point. The bench drives inputs on the falling edge and samples outputs on the next falling edge, so every check falls exactly one register stage after its stimulus. It then samples once more to confirm that responses and strobes are single-cycle pulses. Ignored stimuli are checked by observing the forward and response outputs in the cycle where they would otherwise have appeared.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LEN_W  = 3;
  localparam int OFS_W  = 8;
  localparam int SLOT_W = 8;
  localparam int NSLOTS = 1 << SLOT_W;

  // All-ones read data sized to the access length; unknown lengths act as 4 bytes.
  function automatic logic [DATA_W-1:0] miss_data(input logic [LEN_W-1:0] len);
    case (len)
      3'd1:    miss_data = 32'h0000_00FF;
      3'd2:    miss_data = 32'h0000_FFFF;
      default: miss_data = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/cfgr_decode.sv
module cfgr_decode
  import cfgr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter logic [NSLOTS-1:0] PRESENT = '1,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic [23:0]       addr_lo,
  output logic              hit,
  output logic [PORT_W-1:0] port,
  output logic [2:0]        func,
  output logic [OFS_W-1:0]  offset
);
  logic [7:0]        bus_num;
  logic [SLOT_W-1:0] slot;
  logic [4:0]        dev;

  always_comb begin
    bus_num = addr_lo[23:16];
    slot    = addr_lo[15:8];
    offset  = addr_lo[7:0];
    dev     = slot[7:3];
    func    = slot[2:0];
    hit     = (bus_num == 8'd0) && PRESENT[slot];
    port    = PORT_W'(dev % 5'(NUM_PORTS));
  end
endmodule

// File: rtl/cfgr_fwd.sv
module cfgr_fwd
  import cfgr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 accept,
  input  logic                 hit,
  input  logic [PORT_W-1:0]    port,
  input  logic                 write,
  input  logic [2:0]           func,
  input  logic [OFS_W-1:0]     offset,
  input  logic [LEN_W-1:0]     len,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NUM_PORTS-1:0] fwd_valid,
  output logic                 fwd_write,
  output logic [2:0]           fwd_func,
  output logic [OFS_W-1:0]     fwd_offset,
  output logic [LEN_W-1:0]     fwd_len,
  output logic [DATA_W-1:0]    fwd_wdata
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_strobe
    always_ff @(posedge clk) begin
      if (rst) fwd_valid[p] <= 1'b0;
      else     fwd_valid[p] <= accept && hit && (port == PORT_W'(p));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_write  <= 1'b0;
      fwd_func   <= '0;
      fwd_offset <= '0;
      fwd_len    <= '0;
      fwd_wdata  <= '0;
    end else if (accept && hit) begin
      fwd_write  <= write;
      fwd_func   <= func;
      fwd_offset <= offset;
      fwd_len    <= len;
      fwd_wdata  <= wdata;
    end
  end

  AST_FWD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fwd_valid));  // R2
endmodule

// File: rtl/cfgr_rsp.sv
module cfgr_rsp
  import cfgr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        accept,
  input  logic                        hit,
  input  logic                        write,
  input  logic [PORT_W-1:0]           port,
  input  logic [LEN_W-1:0]            len,
  input  logic [NUM_PORTS-1:0]        port_rsp_valid,
  input  logic [NUM_PORTS*DATA_W-1:0] port_rsp_rdata,
  output logic                        busy,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata
);
  typedef enum logic {ST_IDLE, ST_WAIT} st_t;
  st_t               state;
  logic [PORT_W-1:0] sel_port;
  logic              sel_done;
  logic [DATA_W-1:0] sel_data;

  always_comb begin
    sel_done = port_rsp_valid[sel_port];
    sel_data = port_rsp_rdata[sel_port*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      sel_port  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept && !write) begin
            if (hit) begin
              state    <= ST_WAIT;
              sel_port <= port;
            end else begin
              rsp_valid <= 1'b1;
              rsp_rdata <= miss_data(len);
            end
          end
        end
        ST_WAIT: begin
          if (sel_done) begin
            state     <= ST_IDLE;
            rsp_valid <= 1'b1;
            rsp_rdata <= sel_data;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state == ST_WAIT);

  AST_BUSY_ENDS_WITH_RSP: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> rsp_valid);  // R6
  AST_NO_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !rsp_valid);  // R6
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfgr_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter logic [NSLOTS-1:0] PRESENT = (NSLOTS'(1) << 8'h00) | (NSLOTS'(1) << 8'h08) |
                                         (NSLOTS'(1) << 8'h10) | (NSLOTS'(1) << 8'h11) |
                                         (NSLOTS'(1) << 8'h19),
  localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [LEN_W-1:0]            req_len,
  input  logic [DATA_W-1:0]           req_wdata,
  output logic                        busy,
  output logic                        rsp_valid,
  output logic [DATA_W-1:0]           rsp_rdata,
  output logic [NUM_PORTS-1:0]        fwd_valid,
  output logic                        fwd_write,
  output logic [2:0]                  fwd_func,
  output logic [OFS_W-1:0]            fwd_offset,
  output logic [LEN_W-1:0]            fwd_len,
  output logic [DATA_W-1:0]           fwd_wdata,
  input  logic [NUM_PORTS-1:0]        fwd_rsp_valid,
  input  logic [NUM_PORTS*DATA_W-1:0] fwd_rsp_rdata
);
  logic              hit;
  logic [PORT_W-1:0] port;
  logic [2:0]        func;
  logic [OFS_W-1:0]  offset;
  logic              accept;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^req_addr[31:24];
  assign accept = req_valid && !busy;

  cfgr_decode #(.NUM_PORTS(NUM_PORTS), .PRESENT(PRESENT)) u_decode (
    .addr_lo(req_addr[23:0]), .hit(hit), .port(port), .func(func), .offset(offset)
  );

  cfgr_fwd #(.NUM_PORTS(NUM_PORTS)) u_fwd (
    .clk(clk), .rst(rst), .accept(accept), .hit(hit), .port(port),
    .write(req_write), .func(func), .offset(offset), .len(req_len), .wdata(req_wdata),
    .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_func(fwd_func),
    .fwd_offset(fwd_offset), .fwd_len(fwd_len), .fwd_wdata(fwd_wdata)
  );

  cfgr_rsp #(.NUM_PORTS(NUM_PORTS)) u_rsp (
    .clk(clk), .rst(rst), .accept(accept), .hit(hit), .write(req_write),
    .port(port), .len(req_len), .port_rsp_valid(fwd_rsp_valid),
    .port_rsp_rdata(fwd_rsp_rdata), .busy(busy), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata)
  );

  AST_MISS_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    (accept && !hit) |=> (fwd_valid == '0));  // R3
  AST_NO_FWD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (fwd_valid == '0));  // R7
  AST_WRITE_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (accept && req_write) |=> !busy && !rsp_valid);  // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!busy && !rsp_valid && fwd_valid == '0));  // R8
endmodule

// File: tb/test_cfg_access_router.sv
`timescale 1ns/1ps
module test_cfg_access_router;
  localparam int NP = 4;

  typedef struct packed {
    logic        wr;
    logic [31:0] addr;
    logic [2:0]  len;
    logic [31:0] wdata;
    logic        hit;
    logic [1:0]  port;
    logic [31:0] rdata;
  } vec_t;

  // Present slots in the default mask: 0x00, 0x08, 0x10, 0x11, 0x19.
  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h0000_0004, 3'd2, 32'h0000_0106, 1'b1, 2'd0, 32'h0},
    '{1'b1, 32'h0000_113C, 3'd1, 32'h0000_000B, 1'b1, 2'd2, 32'h0},
    '{1'b0, 32'h0000_0800, 3'd4, 32'h0,         1'b1, 2'd1, 32'hD001_0000},
    '{1'b0, 32'h0000_1910, 3'd4, 32'h0,         1'b1, 2'd3, 32'hD003_0010},
    '{1'b0, 32'h0000_1800, 3'd1, 32'h0,         1'b0, 2'd0, 32'h0000_00FF},
    '{1'b0, 32'h0000_2000, 3'd2, 32'h0,         1'b0, 2'd0, 32'h0000_FFFF},
    '{1'b0, 32'h0001_0000, 3'd4, 32'h0,         1'b0, 2'd0, 32'hFFFF_FFFF},
    '{1'b1, 32'h0002_0810, 3'd4, 32'h1234_5678, 1'b0, 2'd0, 32'h0},
    '{1'b1, 32'h0000_0104, 3'd4, 32'hCAFE_0001, 1'b0, 2'd0, 32'h0},
    '{1'b0, 32'h0000_1800, 3'd3, 32'h0,         1'b0, 2'd0, 32'hFFFF_FFFF},
    '{1'b0, 32'h0000_1800, 3'd0, 32'h0,         1'b0, 2'd0, 32'hFFFF_FFFF},
    '{1'b0, 32'hAB00_1008, 3'd2, 32'h0,         1'b1, 2'd2, 32'hD002_0008}
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid, req_write;
  logic [31:0]       req_addr, req_wdata;
  logic [2:0]        req_len;
  logic              busy, rsp_valid;
  logic [31:0]       rsp_rdata;
  logic [NP-1:0]     fwd_valid, fwd_rsp_valid;
  logic              fwd_write;
  logic [2:0]        fwd_func, fwd_len;
  logic [7:0]        fwd_offset;
  logic [31:0]       fwd_wdata;
  logic [NP*32-1:0]  fwd_rsp_rdata;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  cfg_access_router #(.NUM_PORTS(NP)) i_cfg_access_router (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_func(fwd_func),
    .fwd_offset(fwd_offset), .fwd_len(fwd_len), .fwd_wdata(fwd_wdata),
    .fwd_rsp_valid(fwd_rsp_valid), .fwd_rsp_rdata(fwd_rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic wr, input logic [31:0] a, input logic [2:0] l,
                      input logic [31:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_len = l; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic port_reply(input int p, input logic [31:0] d);
    fwd_rsp_valid = '0;
    fwd_rsp_valid[p] = 1'b1;
    fwd_rsp_rdata[p*32 +: 32] = d;
    @(posedge clk);
    @(negedge clk);
    fwd_rsp_valid = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_len = '0; req_wdata = '0; fwd_rsp_valid = '0; fwd_rsp_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: quiet outputs after reset
    chk("R8 busy", 32'(busy), 32'd0);
    chk("R8 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R8 fwd_valid", 32'(fwd_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      v = VEC[i];
      if (v.hit) tg = v.wr ? "R2" : "R6";
      else if (v.wr) tg = "R3";
      else if (v.len == 3'd1 || v.len == 3'd2 || v.len == 3'd4) tg = "R4";
      else tg = "R5";
      send(v.wr, v.addr, v.len, v.wdata);
      if (v.hit) begin
        chk({tg, " R1 fwd_valid"}, 32'(fwd_valid), 32'(1) << v.port);
        chk({tg, " R1 fwd_func"}, 32'(fwd_func), 32'(v.addr[10:8]));
        chk({tg, " R2 fwd_offset"}, 32'(fwd_offset), 32'(v.addr[7:0]));
        chk({tg, " R2 fwd_len"}, 32'(fwd_len), 32'(v.len));
        chk({tg, " R2 fwd_write"}, 32'(fwd_write), 32'(v.wr));
        if (v.wr) chk({tg, " R2 fwd_wdata"}, fwd_wdata, v.wdata);
      end else begin
        chk({tg, " no forward"}, 32'(fwd_valid), 32'd0);
      end
      if (v.wr) begin
        chk({tg, " R9 busy"}, 32'(busy), 32'd0);
        chk({tg, " R9 rsp_valid"}, 32'(rsp_valid), 32'd0);
      end else if (!v.hit) begin
        chk({tg, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({tg, " rsp_rdata"}, rsp_rdata, v.rdata);
      end else begin
        chk({tg, " busy"}, 32'(busy), 32'd1);
        chk({tg, " early rsp"}, 32'(rsp_valid), 32'd0);
        port_reply(int'(v.port), v.rdata);
        chk({tg, " rsp_valid"}, 32'(rsp_valid), 32'd1);
        chk({tg, " rsp_rdata"}, rsp_rdata, v.rdata);
        chk({tg, " busy cleared"}, 32'(busy), 32'd0);
      end
      @(negedge clk);
      chk({tg, " pulse ends"}, 32'(rsp_valid | (|fwd_valid)), 32'd0);
    end

    // R7: request while busy is ignored; R6: wrong-port reply ignored
    send(1'b0, 32'h0000_0840, 3'd4, 32'h0);
    chk("R6 busy after read hit", 32'(busy), 32'd1);
    send(1'b1, 32'h0000_0010, 3'd4, 32'h5555_AAAA);
    chk("R7 no forward while busy", 32'(fwd_valid), 32'd0);
    chk("R7 no response while busy", 32'(rsp_valid), 32'd0);
    port_reply(0, 32'hBAD0_BAD0);
    chk("R6 wrong port ignored", 32'(rsp_valid), 32'd0);
    chk("R6 still busy", 32'(busy), 32'd1);
    port_reply(1, 32'h1111_0040);
    chk("R6 right port rsp_valid", 32'(rsp_valid), 32'd1);
    chk("R6 right port data", rsp_rdata, 32'h1111_0040);
    @(negedge clk);
    chk("R7 dropped write never forwarded", 32'(fwd_valid), 32'd0);

    // R4: back-to-back missed reads each answer one cycle later
    send(1'b0, 32'h0000_FF00, 3'd2, 32'h0);
    chk("R4 b2b first", rsp_rdata, 32'h0000_FFFF);
    send(1'b0, 32'h0003_0000, 3'd1, 32'h0);
    chk("R4 b2b second valid", 32'(rsp_valid), 32'd1);
    chk("R4 b2b second data", rsp_rdata, 32'h0000_00FF);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule